// File: doc/BRIEF.md
# Feature Access Trap Checker

This block holds a 64-bit feature access control word and, for each instruction class presented to it, decides whether execution must be trapped. When it traps, it also reports the exception level that takes the trap and the 6-bit exception class code. The control word is written through a plain write port and can be read back at any time. The word has five live fields:

- three 2-bit enable fields, one each for matrix, vector and SIMD/floating-point;
- a trace trap bit;
- an EL0 enable for the permission-overlay register.

All other bits of the word read as zero.

A check request carries the following inputs:

- the current exception level;
- a hypervisor-enabled flag;
- a trap-general flag;
- a host-mode flag;
- a 3-bit instruction class.

One cycle later the block returns a result valid strobe with the trap decision. Several fields can apply to the same instruction. The decision logic evaluates them together and resolves them in a fixed order, so that a trap from a specialised enable wins over a trap from the general SIMD/FP enable. Host mode combined with trap-general switches the word off entirely.

Top module: `feat_trap_chk`

## Requirements
- R1: After reset, ctrl_o is all zeros and res_valid_o is 0.
- R2: When wr_en_i is 1, a write stores only the live fields and every other bit of ctrl_o reads 0. The live fields are: overlay enable at bit 29, trace trap at bit 28, matrix enable at [25:24], SIMD/FP enable at [21:20] and vector enable at [17:16].
- R3: Each 2-bit enable field works as follows. Values 00 and 10 trap at EL0 and EL1. Value 01 traps only at EL0. Value 11 traps nothing.
- R4: Class 0 (trace register access) traps at EL0 and EL1 when bit 28 is 1, with code 0x18. When bit 28 is 0 it never traps.
- R5: Class 5 (permission-overlay access) traps only at EL0 and only when bit 29 is 0, with code 0x18.
- R6: Class 1 (matrix) and class 3 (streaming vector) are governed by the matrix enable, with code 0x1D. If that enable does not trap, the SIMD/FP enable is applied instead.
- R7: Class 2 (non-streaming vector) is governed by the vector enable, with code 0x19. If that enable does not trap, the SIMD/FP enable is applied instead.
- R8: Class 4 (SIMD/FP) is governed by the SIMD/FP enable. Any SIMD/FP-enable trap reports code 0x07 when the target is EL1 and 0x00 when the target is EL2.
- R9: The target level is EL2 (2) when hyp_en_i and tge_i are both 1, and EL1 (1) otherwise.
- R10: When host_i and tge_i are both 1, no trap is raised, whatever the control word holds.
- R11: Requests at EL2 or EL3 never trap. Classes 6 and 7 never trap.
- R12: The result appears one cycle after chk_valid_i, with res_valid_o set. A check in the same cycle as a write uses the word as it was before that write. When trap_o is 0, target_el_o and ec_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 64 | Write data |
| ctrl_o | output | 64 | Current control word |
| chk_valid_i | input | 1 | Check request |
| cur_el_i | input | 2 | Exception level of the instruction |
| hyp_en_i | input | 1 | Hypervisor enabled in the current state |
| tge_i | input | 1 | Hypervisor trap-general flag |
| host_i | input | 1 | Host-mode flag |
| cls_i | input | 3 | Instruction class (0 trace, 1 matrix, 2 vector, 3 streaming vector, 4 SIMD/FP, 5 overlay) |
| res_valid_o | output | 1 | Result valid, one cycle after chk_valid_i |
| trap_o | output | 1 | Instruction must be trapped |
| target_el_o | output | 2 | Level taking the trap |
| ec_o | output | 6 | Exception class code |

## Verification
A control-word write and a check request can fall in the same cycle. In that case the decision must follow the old word, and the new word governs only the following request. Random stimulus raises the write strobe and the check strobe independently, so the two coincide often. Directed steps also force a write that flips an enable from trapping to open together with a check that must still trap. The bench's reference model is fed the shadow word as it stood before the write, and the next check confirms the new value took effect.

// File: rtl/feat_trap_pkg.sv
package feat_trap_pkg;
  localparam int REG_W   = 64;
  localparam int OVL_BIT = 29;
  localparam int TRC_BIT = 28;
  localparam int MAT_LO  = 24;
  localparam int FP_LO   = 20;
  localparam int VEC_LO  = 16;
  localparam int N_FLD   = 3;   // 0 matrix, 1 vector, 2 simd/fp
  localparam int FLD_MAT = 0;
  localparam int FLD_VEC = 1;
  localparam int FLD_FP  = 2;

  localparam logic [2:0] CLS_TRACE   = 3'd0;
  localparam logic [2:0] CLS_MATRIX  = 3'd1;
  localparam logic [2:0] CLS_VEC     = 3'd2;
  localparam logic [2:0] CLS_VEC_STR = 3'd3;
  localparam logic [2:0] CLS_FPSIMD  = 3'd4;
  localparam logic [2:0] CLS_OVERLAY = 3'd5;

  localparam logic [5:0] EC_SYSREG = 6'h18;
  localparam logic [5:0] EC_VEC    = 6'h19;
  localparam logic [5:0] EC_MAT    = 6'h1D;
  localparam logic [5:0] EC_FP_EL1 = 6'h07;
  localparam logic [5:0] EC_FP_EL2 = 6'h00;

  typedef struct packed {
    logic       trap;
    logic [1:0] tgt;
    logic [5:0] ec;
  } verdict_t;
endpackage

// File: rtl/feat_trap_ctrl_reg.sv
module feat_trap_ctrl_reg
  import feat_trap_pkg::*;
#(
  parameter int W         = REG_W,
  parameter bit HAS_TRACE = 1'b1,
  parameter bit HAS_OVL   = 1'b1,
  parameter bit HAS_MAT   = 1'b1,
  parameter bit HAS_VEC   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TWO  = W'(3);
  localparam logic [W-1:0] WR_MASK =
      (HAS_OVL   ? (ONE << OVL_BIT) : '0) |
      (HAS_TRACE ? (ONE << TRC_BIT) : '0) |
      (HAS_MAT   ? (TWO << MAT_LO)  : '0) |
      (HAS_VEC   ? (TWO << VEC_LO)  : '0) |
      (TWO << FP_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wr_data_i & WR_MASK;
  end
endmodule

// File: rtl/feat_trap_fld_eval.sv
module feat_trap_fld_eval (
  input  logic [1:0] fld_i,
  input  logic       at_el0_i,
  output logic       trap_o
);
  always_comb begin
    unique case (fld_i)
      2'b11:   trap_o = 1'b0;
      2'b01:   trap_o = at_el0_i;
      default: trap_o = 1'b1;   // 00 and 10
    endcase
  end
endmodule

// File: rtl/feat_trap_resolve.sv
module feat_trap_resolve
  import feat_trap_pkg::*;
(
  input  logic             trc_bit_i,
  input  logic             ovl_bit_i,
  input  logic [N_FLD-1:0] fld_trap_i,
  input  logic [1:0]       el_i,
  input  logic             hyp_en_i,
  input  logic             tge_i,
  input  logic             host_i,
  input  logic [2:0]       cls_i,
  output verdict_t         v_o
);
  logic       to_el2;
  logic       active;
  logic       hit;
  logic [5:0] ec;
  logic [5:0] fp_ec;

  assign to_el2 = hyp_en_i & tge_i;
  assign active = ~el_i[1] & ~(host_i & tge_i);
  assign fp_ec  = to_el2 ? EC_FP_EL2 : EC_FP_EL1;

  always_comb begin
    hit = 1'b0;
    ec  = '0;
    unique case (cls_i)
      CLS_TRACE: begin
        hit = trc_bit_i;
        ec  = EC_SYSREG;
      end
      CLS_OVERLAY: begin
        hit = (el_i == 2'd0) & ~ovl_bit_i;
        ec  = EC_SYSREG;
      end
      CLS_MATRIX, CLS_VEC_STR: begin
        if (fld_trap_i[FLD_MAT]) begin
          hit = 1'b1; ec = EC_MAT;
        end else if (fld_trap_i[FLD_FP]) begin
          hit = 1'b1; ec = fp_ec;
        end
      end
      CLS_VEC: begin
        if (fld_trap_i[FLD_VEC]) begin
          hit = 1'b1; ec = EC_VEC;
        end else if (fld_trap_i[FLD_FP]) begin
          hit = 1'b1; ec = fp_ec;
        end
      end
      CLS_FPSIMD: begin
        hit = fld_trap_i[FLD_FP];
        ec  = fp_ec;
      end
      default: begin
        hit = 1'b0;
        ec  = '0;
      end
    endcase

    if (active && hit) begin
      v_o.trap = 1'b1;
      v_o.tgt  = to_el2 ? 2'd2 : 2'd1;
      v_o.ec   = ec;
    end else begin
      v_o = '0;
    end
  end
endmodule

// File: rtl/feat_trap_chk.sv
module feat_trap_chk
  import feat_trap_pkg::*;
#(
  parameter bit HAS_TRACE = 1'b1,
  parameter bit HAS_OVL   = 1'b1,
  parameter bit HAS_MAT   = 1'b1,
  parameter bit HAS_VEC   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctrl_o,
  input  logic             chk_valid_i,
  input  logic [1:0]       cur_el_i,
  input  logic             hyp_en_i,
  input  logic             tge_i,
  input  logic             host_i,
  input  logic [2:0]       cls_i,
  output logic             res_valid_o,
  output logic             trap_o,
  output logic [1:0]       target_el_o,
  output logic [5:0]       ec_o
);
  localparam int FLD_LO [N_FLD] = '{MAT_LO, VEC_LO, FP_LO};

  logic [REG_W-1:0] ctrl_q;
  logic [N_FLD-1:0] fld_trap;
  verdict_t         v_d, v_q;
  logic             vld_q;

  feat_trap_ctrl_reg #(
    .W(REG_W), .HAS_TRACE(HAS_TRACE), .HAS_OVL(HAS_OVL),
    .HAS_MAT(HAS_MAT), .HAS_VEC(HAS_VEC)
  ) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .q_o(ctrl_q)
  );

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    feat_trap_fld_eval u_eval (
      .fld_i   (ctrl_q[FLD_LO[g] +: 2]),
      .at_el0_i(cur_el_i == 2'd0),
      .trap_o  (fld_trap[g])
    );
  end

  feat_trap_resolve u_res (
    .trc_bit_i (ctrl_q[TRC_BIT]),
    .ovl_bit_i (ctrl_q[OVL_BIT]),
    .fld_trap_i(fld_trap),
    .el_i      (cur_el_i),
    .hyp_en_i,
    .tge_i,
    .host_i,
    .cls_i,
    .v_o       (v_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      v_q   <= '0;
    end else begin
      vld_q <= chk_valid_i;
      v_q   <= chk_valid_i ? v_d : '0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign res_valid_o = vld_q;
  assign trap_o      = v_q.trap;
  assign target_el_o = v_q.tgt;
  assign ec_o        = v_q.ec;
endmodule

// File: rtl/feat_trap_chk_sva.sv
module feat_trap_chk_sva #(
  parameter logic [63:0] LIVE = 64'h0000_0000_3333_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] ctrl_o,
  input logic        chk_valid_i,
  input logic [1:0]  cur_el_i,
  input logic        hyp_en_i,
  input logic        tge_i,
  input logic        host_i,
  input logic [2:0]  cls_i,
  input logic        res_valid_o,
  input logic        trap_o,
  input logic [1:0]  target_el_o,
  input logic [5:0]  ec_o
);
  p_res0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & ~LIVE) == 64'h0);

  p_mat_ec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && cls_i == 3'd1 && cur_el_i == 2'd1 && !(host_i && tge_i)
      && !ctrl_o[24] |=> trap_o && ec_o == 6'h1D);

  p_ovl_el1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && cls_i == 3'd5 && cur_el_i != 2'd0 |=> !trap_o);

  p_tgt_el2_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && hyp_en_i && tge_i |=> !trap_o || target_el_o == 2'd2);

  p_tgt_el1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && !(hyp_en_i && tge_i) |=> !trap_o || target_el_o == 2'd1);

  p_host_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && host_i && tge_i |=> !trap_o);

  p_high_el_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && cur_el_i[1] |=> !trap_o);

  p_vld_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> res_valid_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !res_valid_o && !trap_o);

  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> target_el_o == 2'd0 && ec_o == 6'h0);
endmodule

bind feat_trap_chk feat_trap_chk_sva u_sva (.*);

// File: tb/feat_trap_chk_test.sv
module feat_trap_chk_test;
  localparam time CLK_P = 10ns;
  localparam logic [63:0] LIVE = 64'h0000_0000_3333_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] ctrl_o;
  logic        chk_valid_i = 1'b0;
  logic [1:0]  cur_el_i = '0;
  logic        hyp_en_i = 1'b0, tge_i = 1'b0, host_i = 1'b0;
  logic [2:0]  cls_i = '0;
  logic        res_valid_o, trap_o;
  logic [1:0]  target_el_o;
  logic [5:0]  ec_o;

  int checks = 0, errors = 0;
  logic [63:0] sh = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  feat_trap_chk uut (.*);

  function automatic logic ft(logic [1:0] f, logic el0);
    if (f == 2'b11) return 1'b0;
    if (f == 2'b01) return el0;
    return 1'b1;
  endfunction

  // {trap, tgt, ec}
  function automatic logic [8:0] model(logic [63:0] r, logic [1:0] el,
                                       logic hyp, logic tge, logic host,
                                       logic [2:0] cls);
    logic t; logic [5:0] e; logic [1:0] tg; logic [5:0] fe; logic el0;
    t = 1'b0; e = '0; el0 = (el == 2'd0);
    tg = (hyp && tge) ? 2'd2 : 2'd1;
    fe = (hyp && tge) ? 6'h00 : 6'h07;
    if (el < 2 && !(host && tge)) begin
      case (cls)
        3'd0: begin t = r[28]; e = 6'h18; end
        3'd5: begin t = el0 && !r[29]; e = 6'h18; end
        3'd1, 3'd3: begin
          if (ft(r[25:24], el0)) begin t = 1; e = 6'h1D; end
          else if (ft(r[21:20], el0)) begin t = 1; e = fe; end
        end
        3'd2: begin
          if (ft(r[17:16], el0)) begin t = 1; e = 6'h19; end
          else if (ft(r[21:20], el0)) begin t = 1; e = fe; end
        end
        3'd4: begin t = ft(r[21:20], el0); e = fe; end
        default: t = 1'b0;
      endcase
    end
    if (!t) return 9'h0;
    return {t, tg, e};
  endfunction

  function automatic string tag_of(logic [2:0] cls, logic [1:0] el,
                                   logic host, logic tge);
    if (host && tge) return "R10";
    if (el >= 2)     return "R11";
    case (cls)
      3'd0: return "R4";
      3'd5: return "R5";
      3'd1, 3'd3: return "R6";
      3'd2: return "R7";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(string tag, logic v, logic [8:0] exp);
    logic [9:0] act;
    act = {res_valid_o, trap_o, target_el_o, ec_o};
    checks++;
    if (act !== {v, exp}) begin
      errors++;
      $display("FAIL %s: act vld=%b trap=%b tgt=%0d ec=%h exp vld=%b trap=%b tgt=%0d ec=%h",
               tag, act[9], act[8], act[7:6], act[5:0], v, exp[8], exp[7:6], exp[5:0]);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic step(string tag, logic we, logic [63:0] wd, logic cv,
                      logic [1:0] el, logic hyp, logic tge, logic host,
                      logic [2:0] cls);
    logic [8:0] exp;
    wr_en_i = we; wr_data_i = wd; chk_valid_i = cv;
    cur_el_i = el; hyp_en_i = hyp; tge_i = tge; host_i = host; cls_i = cls;
    exp = cv ? model(sh, el, hyp, tge, host, cls) : 9'h0;
    @(posedge clk_i);
    if (we) sh = wd & LIVE;
    @(negedge clk_i);
    wr_en_i = 1'b0; chk_valid_i = 1'b0;
    cmp(tag, cv, exp);
  endtask

  task automatic wr(logic [63:0] d);
    step("R2", 1'b1, d, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic chk_ctrl(string tag, logic [63:0] exp);
    checks++;
    if (ctrl_o !== exp) begin
      errors++;
      $display("FAIL %s: ctrl act=%h exp=%h", tag, ctrl_o, exp);
    end
  endtask

  // field helper: ovl, trc, mat, fp, vec
  function automatic logic [63:0] mk(logic o, logic t, logic [1:0] m,
                                     logic [1:0] f, logic [1:0] v);
    return (64'(o) << 29) | (64'(t) << 28) | (64'(m) << 24) |
           (64'(f) << 20) | (64'(v) << 16);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    chk_ctrl("R1", 64'h0);
    checks++;
    if (res_valid_o !== 1'b0) begin
      errors++; $display("FAIL R1: res_valid act=%b exp=0", res_valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr('1);
    chk_ctrl("R2", LIVE);
    wr(64'hFFFF_FFFF_CCCC_FFFF);
    chk_ctrl("R2", 64'h0);

    // R3 field encodings on the SIMD/FP enable
    wr(mk(1, 0, 2'b11, 2'b01, 2'b11));
    step("R3", 0, 0, 1, 2'd0, 0, 0, 0, 3'd4);
    step("R3", 0, 0, 1, 2'd1, 0, 0, 0, 3'd4);
    wr(mk(1, 0, 2'b11, 2'b10, 2'b11));
    step("R3", 0, 0, 1, 2'd1, 0, 0, 0, 3'd4);
    wr(mk(1, 0, 2'b11, 2'b11, 2'b11));
    step("R3", 0, 0, 1, 2'd0, 0, 0, 0, 3'd4);

    // R4 trace
    step("R4", 0, 0, 1, 2'd1, 0, 0, 0, 3'd0);
    wr(mk(1, 1, 2'b11, 2'b11, 2'b11));
    step("R4", 0, 0, 1, 2'd1, 0, 0, 0, 3'd0);

    // R5 overlay
    wr(mk(0, 0, 2'b11, 2'b11, 2'b11));
    step("R5", 0, 0, 1, 2'd0, 0, 0, 0, 3'd5);
    step("R5", 0, 0, 1, 2'd1, 0, 0, 0, 3'd5);

    // R6 matrix over fp, streaming vector under matrix enable
    wr(mk(1, 0, 2'b00, 2'b00, 2'b11));
    step("R6", 0, 0, 1, 2'd1, 0, 0, 0, 3'd1);
    wr(mk(1, 0, 2'b11, 2'b00, 2'b11));
    step("R6", 0, 0, 1, 2'd1, 0, 0, 0, 3'd1);
    wr(mk(1, 0, 2'b11, 2'b11, 2'b00));
    step("R6", 0, 0, 1, 2'd1, 0, 0, 0, 3'd3);

    // R7 vector over fp
    step("R7", 0, 0, 1, 2'd1, 0, 0, 0, 3'd2);
    wr(mk(1, 0, 2'b00, 2'b10, 2'b01));
    step("R7", 0, 0, 1, 2'd1, 0, 0, 0, 3'd2);

    // R8 / R9 fp code by target
    step("R8", 0, 0, 1, 2'd1, 1, 1, 0, 3'd4);
    step("R9", 0, 0, 1, 2'd0, 1, 0, 0, 3'd4);

    // R10 host override, R11 high levels
    step("R10", 0, 0, 1, 2'd0, 1, 1, 1, 3'd4);
    step("R11", 0, 0, 1, 2'd2, 0, 0, 0, 3'd4);
    step("R11", 0, 0, 1, 2'd0, 0, 0, 0, 3'd7);

    // R12 write and check in the same cycle: old word governs
    wr(mk(1, 0, 2'b00, 2'b00, 2'b00));
    step("R12", 1, mk(1, 0, 2'b11, 2'b11, 2'b11), 1, 2'd1, 0, 0, 0, 3'd4);
    step("R12", 0, 0, 1, 2'd1, 0, 0, 0, 3'd4);
    step("R12", 0, 0, 0, 2'd0, 0, 0, 0, 3'd4);

    for (int i = 0; i < 800; i++) begin
      logic we, cv, hy, tg, ho;
      logic [1:0] el;
      logic [2:0] cl;
      logic [63:0] wd;
      we = ($urandom % 4) == 0;
      cv = ($urandom % 8) != 0;
      wd = {$urandom, $urandom};
      el = 2'($urandom % 4);
      hy = 1'($urandom); tg = 1'($urandom);
      ho = ($urandom % 4) == 0;
      cl = 3'($urandom % 8);
      step(cv ? tag_of(cl, el, ho, tg) : "R12", we, wd, cv, el, hy, tg, ho, cl);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule